// File: doc/BRIEF.md
# Cascadable Segment Column Data Loader

This block loads one display line into a single segment-driver chip that sits in a chain of identical chips sharing a 4-bit display data bus. A nibble is taken from the bus on each falling edge of a shift clock and placed into an 80-bit data register. Successive nibbles fill successive groups of four columns. A chip accepts nibbles only while its active-low enable input is asserted. Once it holds all 80 bits, it pulls its own active-low enable output low, and the next chip in the chain then takes over the bus.

A line latch pulse ends each line. On its rising edge the data register is copied into a holding latch and the enable logic is rearmed. On its falling edge the 80 segment outputs take the new values. A direction input mirrors the column fill order and swaps which enable pin acts as input and which as output, so a chain can be driven from either end. An active-low blanking input forces every segment to the off level (0) and leaves the stored line untouched.

All inputs are sampled by the system clock `clk`. The shift clock and the latch pulse are edge-detected against their values one `clk` cycle earlier.

Top module: `seg_col_loader`

## Requirements
- R1: With `dir_i` = 0, the nibble captured k-th after a latch pulse (k = 0..19) appears, once the next latch pulse has ended, with bit j on `seg_o[4k+j]`. Bit j is `data_i[j]`.
- R2: A nibble is captured only on a falling edge of `sclk_i` (1 to 0). The value on `data_i` while `sclk_i` is low or rising has no effect.
- R3: With `dir_i` = 1, bit j of the k-th nibble appears on `seg_o[79-4k-j]`.
- R4: The active enable output is high after reset and after a latch pulse. It goes low in the same `clk` cycle in which the 20th nibble is captured.
- R5: With `dir_i` = 0, `en_l_n_i` is the enable input and `en_r_n_o` the enable output. With `dir_i` = 1, `en_r_n_i` is the input and `en_l_n_o` the output. The unused output is held high.
- R6: While the selected enable input is high, shift clock edges change nothing.
- R7: After 20 nibbles, further shift clock edges are ignored until the next latch pulse.
- R8: The rising edge of `lp_i` copies the data register into the holding latch. `seg_o` changes only at the falling edge of `lp_i` and keeps its old value while `lp_i` is high.
- R9: While `blank_n_i` is 0, every bit of `seg_o` is 0. When it returns to 1, the latched line reappears unchanged.
- R10: After synchronous reset, `seg_o` is all zero and both enable outputs are high.
- R11: A shift clock falling edge in the same `clk` cycle as a rising edge of `lp_i` is discarded. The next line then needs a full 20 new nibbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Display data shift clock |
| lp_i | input | 1 | Line latch pulse |
| data_i | input | 4 | Display data nibble |
| dir_i | input | 1 | Fill direction and enable pin role select |
| blank_n_i | input | 1 | Active-low forced blank |
| en_l_n_i | input | 1 | Left enable input (active low, used when dir_i = 0) |
| en_r_n_i | input | 1 | Right enable input (active low, used when dir_i = 1) |
| en_l_n_o | output | 1 | Left enable output (active low, used when dir_i = 1) |
| en_r_n_o | output | 1 | Right enable output (active low, used when dir_i = 0) |
| seg_o | output | 80 | Segment levels, bit 0 = segment 1 |

## Verification
The rising edge of the latch pulse and a falling edge of the shift clock can land in the same system clock cycle. In that cycle the line restart and a nibble capture compete for the column counter. The bench provokes this with five nibbles already loaded, by dropping the shift clock in the very cycle the latch pulse rises. It then judges the result by the enable output: the output must stay high after 19 further nibbles and fall only on the 20th. The segment image that is latched afterwards must hold exactly those 20 nibbles.

// File: rtl/seg_col_loader_pkg.sv
package seg_col_loader_pkg;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } fill_dir_e;

    typedef struct packed {
        logic sh_fall;
        logic lp_rise;
        logic lp_fall;
    } edge_ev_t;

    // Physical nibble slot written by the k-th accepted nibble.
    function automatic int phys_slot(input int k, input int n, input logic rev);
        return rev ? (n - 1 - k) : k;
    endfunction

endpackage

// File: rtl/sl_edge_sync.sv
module sl_edge_sync
    import seg_col_loader_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_i,
    input  logic     lp_i,
    output edge_ev_t ev_o
);
    logic sclk_q;
    logic lp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            lp_q   <= 1'b0;
        end else begin
            sclk_q <= sclk_i;
            lp_q   <= lp_i;
        end
    end

    always_comb begin
        ev_o.sh_fall = sclk_q & ~sclk_i;
        ev_o.lp_rise = lp_i & ~lp_q;
        ev_o.lp_fall = lp_q & ~lp_i;
    end
endmodule

// File: rtl/sl_chain_ctrl.sv
module sl_chain_ctrl
    import seg_col_loader_pkg::*;
#(
    parameter int NIB_N = 20,
    localparam int CNT_W = $clog2(NIB_N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sh_fall,
    input  logic             lp_rise,
    input  fill_dir_e        dir,
    input  logic             en_l_n_i,
    input  logic             en_r_n_i,
    output logic             en_l_n_o,
    output logic             en_r_n_o,
    output logic             wr_o,
    output logic [CNT_W-1:0] idx_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             full;
    logic             en_in_n;

    assign en_in_n = (dir == DIR_FWD) ? en_l_n_i : en_r_n_i;
    assign full    = (cnt_q == CNT_W'(NIB_N));
    assign wr_o    = sh_fall & ~lp_rise & ~en_in_n & ~full;
    assign idx_o   = cnt_q;

    assign en_r_n_o = (dir == DIR_FWD) ? ~full : 1'b1;
    assign en_l_n_o = (dir == DIR_REV) ? ~full : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (lp_rise) begin
            cnt_q <= '0;
        end else if (wr_o) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(NIB_N));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (en_in_n && !lp_rise) |=> $stable(cnt_q));

    assert_edge_only_R2: assert property (@(posedge clk) disable iff (rst)
        (!sh_fall && !lp_rise) |=> $stable(cnt_q));

    assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
        lp_rise |=> (cnt_q == '0));
endmodule

// File: rtl/sl_data_reg.sv
module sl_data_reg
    import seg_col_loader_pkg::*;
#(
    parameter int SEG_N = 80,
    parameter int NIB_W = 4,
    localparam int NIB_N = SEG_N / NIB_W,
    localparam int CNT_W = $clog2(NIB_N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] idx_i,
    input  fill_dir_e        dir,
    input  logic [NIB_W-1:0] din_i,
    output logic [SEG_N-1:0] dreg_o
);
    logic [NIB_W-1:0] slot_q [NIB_N];
    logic [NIB_W-1:0] din_rev;
    int               phys;

    always_comb begin
        for (int j = 0; j < NIB_W; j++) begin
            din_rev[NIB_W-1-j] = din_i[j];
        end
        phys = phys_slot(int'(idx_i), NIB_N, dir == DIR_REV);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NIB_N; p++) begin
                slot_q[p] <= '0;
            end
        end else if (wr_i) begin
            for (int p = 0; p < NIB_N; p++) begin
                if (p == phys) begin
                    slot_q[p] <= (dir == DIR_REV) ? din_rev : din_i;
                end
            end
        end
    end

    for (genvar p = 0; p < NIB_N; p++) begin : g_flat
        assign dreg_o[p*NIB_W +: NIB_W] = slot_q[p];
    end

    assert_no_write_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(dreg_o));
endmodule

// File: rtl/sl_out_latch.sv
module sl_out_latch #(
    parameter int SEG_N = 80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lp_rise,
    input  logic             lp_fall,
    input  logic             blank_n_i,
    input  logic [SEG_N-1:0] dreg_i,
    output logic [SEG_N-1:0] seg_o
);
    logic [SEG_N-1:0] hold_q;
    logic [SEG_N-1:0] seg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            seg_q  <= '0;
        end else begin
            if (lp_rise) hold_q <= dreg_i;
            if (lp_fall) seg_q  <= hold_q;
        end
    end

    assign seg_o = blank_n_i ? seg_q : '0;

    assert_seg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !lp_fall |=> $stable(seg_q));

    assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
        lp_rise |=> (hold_q == $past(dreg_i)));

    assert_blank_R9: assert property (@(posedge clk) disable iff (rst)
        !blank_n_i |-> (seg_o == '0));
endmodule

// File: rtl/seg_col_loader.sv
module seg_col_loader
    import seg_col_loader_pkg::*;
#(
    parameter int SEG_N = 80,
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_i,
    input  logic             lp_i,
    input  logic [NIB_W-1:0] data_i,
    input  logic             dir_i,
    input  logic             blank_n_i,
    input  logic             en_l_n_i,
    input  logic             en_r_n_i,
    output logic             en_l_n_o,
    output logic             en_r_n_o,
    output logic [SEG_N-1:0] seg_o
);
    localparam int NIB_N = SEG_N / NIB_W;
    localparam int CNT_W = $clog2(NIB_N + 1);

    edge_ev_t         ev;
    fill_dir_e        dir;
    logic             wr;
    logic [CNT_W-1:0] idx;
    logic [SEG_N-1:0] dreg;
    logic             sh_fall;
    logic             lp_rise;
    logic             lp_fall;

    assign dir     = fill_dir_e'(dir_i);
    assign sh_fall = ev.sh_fall;
    assign lp_rise = ev.lp_rise;
    assign lp_fall = ev.lp_fall;

    sl_edge_sync u_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .lp_i   (lp_i),
        .ev_o   (ev)
    );

    sl_chain_ctrl #(.NIB_N(NIB_N)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sh_fall  (sh_fall),
        .lp_rise  (lp_rise),
        .dir      (dir),
        .en_l_n_i (en_l_n_i),
        .en_r_n_i (en_r_n_i),
        .en_l_n_o (en_l_n_o),
        .en_r_n_o (en_r_n_o),
        .wr_o     (wr),
        .idx_o    (idx)
    );

    sl_data_reg #(.SEG_N(SEG_N), .NIB_W(NIB_W)) u_dreg (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wr),
        .idx_i  (idx),
        .dir    (dir),
        .din_i  (data_i),
        .dreg_o (dreg)
    );

    sl_out_latch #(.SEG_N(SEG_N)) u_out (
        .clk       (clk),
        .rst       (rst),
        .lp_rise   (lp_rise),
        .lp_fall   (lp_fall),
        .blank_n_i (blank_n_i),
        .dreg_i    (dreg),
        .seg_o     (seg_o)
    );

    assert_unused_out_high_R5: assert property (@(posedge clk) disable iff (rst)
        (dir_i ? en_r_n_o : en_l_n_o) == 1'b1);
endmodule

// File: tb/tb_seg_col_loader.sv
`timescale 1ns/1ps
module tb_seg_col_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1;
    logic        lp = 1'b0;
    logic [3:0]  data = 4'h0;
    logic        dir = 1'b0;
    logic        blank_n = 1'b1;
    logic        a_l_o, a_r_o, b_l_o, b_r_o;
    logic        a_l_i, a_r_i, b_l_i, b_r_i;
    logic [79:0] seg_a, seg_b;
    int          checks = 0;
    int          errors = 0;
    logic [3:0]  nibs [40];

    always #4 clk = ~clk;

    // first chip at the feeding end, second chip downstream in either direction
    assign a_l_i = dir ? 1'b1 : 1'b0;
    assign a_r_i = dir ? 1'b0 : 1'b1;
    assign b_l_i = dir ? 1'b1 : a_r_o;
    assign b_r_i = dir ? a_l_o : 1'b1;

    seg_col_loader dut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .lp_i(lp), .data_i(data),
        .dir_i(dir), .blank_n_i(blank_n), .en_l_n_i(a_l_i), .en_r_n_i(a_r_i),
        .en_l_n_o(a_l_o), .en_r_n_o(a_r_o), .seg_o(seg_a)
    );

    seg_col_loader dut2 (
        .clk(clk), .rst(rst), .sclk_i(sclk), .lp_i(lp), .data_i(data),
        .dir_i(dir), .blank_n_i(blank_n), .en_l_n_i(b_l_i), .en_r_n_i(b_r_i),
        .en_l_n_o(b_l_o), .en_r_n_o(b_r_o), .seg_o(seg_b)
    );

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        finish_up();
    end

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [79:0] image(input int base, input logic rev);
        logic [79:0] v = '0;
        for (int k = 0; k < 20; k++)
            for (int j = 0; j < 4; j++)
                v[rev ? (79 - 4*k - j) : (4*k + j)] = nibs[base + k][j];
        return v;
    endfunction

    // one falling edge with d on the bus; bus changes before the rising edge
    task automatic shift(input logic [3:0] d);
        @(negedge clk); data = d; sclk = 1'b0;
        @(negedge clk); data = ~d;
        @(negedge clk); sclk = 1'b1;
        @(negedge clk);
    endtask

    // latch pulse; outputs checked to stay put while it is high
    task automatic pulse_lp(input string req);
        logic [79:0] pa, pb;
        pa = seg_a; pb = seg_b;
        @(negedge clk); lp = 1'b1;
        repeat (3) @(negedge clk);
        chk({req, " hold while pulse high (chip A)"}, seg_a, pa);
        chk({req, " hold while pulse high (chip B)"}, seg_b, pb);
        lp = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 seg A zero", seg_a, '0);
        chk("R10 seg B zero", seg_b, '0);
        chk("R10 enable outs high", {76'h0, a_l_o, a_r_o, b_l_o, b_r_o}, 80'hF);
    endtask

    task automatic t_line(input logic rev, input int mul, input int add);
        dir = rev;
        pulse_lp("R8 prep");
        for (int i = 0; i < 40; i++) nibs[i] = 4'((i * mul + add) & 15);
        for (int i = 0; i < 20; i++) begin
            shift(nibs[i]);
            if (i == 18) chk("R4 out high before 20th", {79'h0, rev ? a_l_o : a_r_o}, 80'h1);
        end
        chk("R4 out low after 20th", {79'h0, rev ? a_l_o : a_r_o}, 80'h0);
        chk("R5 unused out high", {79'h0, rev ? a_r_o : a_l_o}, 80'h0 | 80'h1);
        for (int i = 20; i < 40; i++) shift(nibs[i]);
        chk("R4 chip B out low after 40", {79'h0, rev ? b_l_o : b_r_o}, 80'h0);
        // extra edges on a full chain must be ignored
        for (int i = 0; i < 3; i++) shift(4'hF ^ 4'(i));
        pulse_lp("R8");
        if (!rev) begin
            chk("R1 chip A forward image", seg_a, image(0, 1'b0));
            chk("R6 R7 R2 chip B forward image", seg_b, image(20, 1'b0));
        end else begin
            chk("R3 chip A reversed image", seg_a, image(0, 1'b1));
            chk("R6 R7 R2 chip B reversed image", seg_b, image(20, 1'b1));
        end
        chk("R4 outs high after pulse", {78'h0, a_l_o & a_r_o, b_l_o & b_r_o}, 80'h3);
    endtask

    task automatic t_blank();
        logic [79:0] ea;
        ea = seg_a;
        @(negedge clk); blank_n = 1'b0;
        @(negedge clk);
        chk("R9 blank A", seg_a, '0);
        chk("R9 blank B", seg_b, '0);
        blank_n = 1'b1;
        @(negedge clk);
        chk("R9 restored A", seg_a, ea);
    endtask

    task automatic t_coincide();
        dir = 1'b0;
        for (int i = 0; i < 5; i++) shift(4'h9);
        @(negedge clk); lp = 1'b1; sclk = 1'b0; data = 4'h5;
        @(negedge clk); lp = 1'b0; sclk = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 20; i++) nibs[i] = 4'((i * 3 + 1) & 15);
        for (int i = 0; i < 19; i++) shift(nibs[i]);
        chk("R11 out high after 19", {79'h0, a_r_o}, 80'h1);
        shift(nibs[19]);
        chk("R11 out low after 20", {79'h0, a_r_o}, 80'h0);
        pulse_lp("R8 coincide");
        chk("R11 image after coincident edge", seg_a, image(0, 1'b0));
    endtask

    initial begin
        t_reset();
        t_line(1'b0, 5, 3);
        t_blank();
        t_line(1'b1, 11, 6);
        t_coincide();
        finish_up();
    end
endmodule